// File: doc/BRIEF.md
# I2C Slave Byte Receiver with Clock Stretching

This block is the receive half of an I2C slave. It watches SCL and SDA through open-drain style pins, spots START and STOP conditions, and compares the first byte after each START with a 7-bit address that software programs. Once it is addressed for a write, it collects data bytes MSB first into a one-byte receive buffer and raises a buffer-full flag. On the ninth clock of each byte it answers with an acknowledge level that software chooses. If the previous byte is still unread when the next byte completes, it holds SCL low until software reads the buffer.

Software sees four byte-wide registers behind a simple read/write port. Offset 0 is control: bit 0 enables the block and bit 1 selects the acknowledge level. Offset 1 holds the own address in bits 6:0. Offset 2 is status, with bit 0 as the buffer-full flag. Offset 3 is the receive buffer, and reading it clears the flag. The acknowledged address byte also lands in the buffer, so the first read after addressing is a dummy read. The pin outputs are pull-down enables: 1 pulls the line low and 0 releases it.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, and whenever control bit 0 is 0, both pull outputs are 0 and the bus is ignored: no acknowledge is driven and nothing is loaded.
- R2: START is SDA falling while SCL is high. The byte after it is taken MSB first on rising SCL edges. It matches only when bits 7:1 equal the own address (offset 1, bits 6:0) and bit 0 (R/W) is 0.
- R3: After a match, SDA is pulled to the acknowledge level from the eighth falling SCL edge until the ninth falling SCL edge. Control bit 1 = 0 pulls SDA low (ACK) and 1 leaves it released (NACK). The SDA pull changes only while SCL is low.
- R4: At the ninth rising SCL edge of the matched address byte, the block loads the address byte ({address, R/W}) into offset 3 and sets status bit 0. Software reads it as a dummy read.
- R5: Each later data byte is loaded into offset 3 at its ninth rising SCL edge and sets status bit 0. A read of offset 3 clears the flag.
- R6: If status bit 0 is still set at the eighth falling SCL edge of a byte, SCL is pulled low until offset 3 is read.
- R7: The acknowledge level is sampled at the first rising SCL edge of each byte. A change written later, even while SCL is held, applies only from the next byte.
- R8: On an address mismatch or R/W = 1, both lines stay released, the byte is not loaded and the following bytes are ignored until the next START.
- R9: A STOP (SDA rising while SCL is high) or a repeated START releases both lines and returns the block to address matching.
- R10: Clearing control bit 0 empties the buffer (offset 3 reads 0) and clears status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (read side effects) |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |

## Verification
The assertions check on every cycle that SCL is pulled only while the buffer is full, and that the SDA pull changes only while SCL is low. They also check that SDA is driven only in an addressed transfer, that the flag rises only two cycles after a rising SCL edge, that a buffer read clears the flag, and that disabling empties it. Only the bench scenarios show the full protocol outcome. Those scenarios cover which address bytes are acknowledged, what values reach the buffer, the acknowledge level taking effect one byte late when changed during a stretch, release of the stretch by the read, and recovery after a repeated START or STOP.

// File: rtl/i2c_rx_pkg.sv
`timescale 1ns/1ps
package i2c_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_SKIP} rx_state_e;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_OWN  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;
endpackage

// File: rtl/i2c_rx_sync.sv
`timescale 1ns/1ps
module i2c_rx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg <= '1;
    else         stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_rx_cond.sv
`timescale 1ns/1ps
module i2c_rx_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // bus conditions need SCL high on both samples
  assign start_o = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o  = scl_s_i & scl_q & ~sda_q & sda_s_i;

  assert_events_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scl_rise_o, scl_fall_o, start_o, stop_o}));
endmodule

// File: rtl/i2c_rx_engine.sv
`timescale 1ns/1ps
module i2c_rx_engine
  import i2c_rx_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ack_level_i,
  input  logic              rx_full_i,
  output logic              load_o,
  output logic [DATA_W-1:0] shift_o,
  output logic              sda_pull_o,
  output logic              hold_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  rx_state_e         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              in_ack;
  logic              ack_eff;
  logic              addr_hit;
  logic              active;

  assign active   = (state == ST_ADDR) || (state == ST_DATA);
  assign addr_hit = (shreg[DATA_W-1:1] == own_addr_i) && !shreg[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      in_ack     <= 1'b0;
      ack_eff    <= 1'b0;
      sda_pull_o <= 1'b0;
      hold_o     <= 1'b0;
      load_o     <= 1'b0;
    end else if (!en_i) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      in_ack     <= 1'b0;
      ack_eff    <= 1'b0;
      sda_pull_o <= 1'b0;
      hold_o     <= 1'b0;
      load_o     <= 1'b0;
    end else begin
      load_o <= 1'b0;
      if (hold_o && !rx_full_i) hold_o <= 1'b0;
      if (start_i || stop_i) begin
        state      <= start_i ? ST_ADDR : ST_IDLE;
        bit_cnt    <= '0;
        in_ack     <= 1'b0;
        sda_pull_o <= 1'b0;
        hold_o     <= 1'b0;
      end else if (active) begin
        if (scl_rise_i) begin
          if (!in_ack) begin
            shreg   <= {shreg[DATA_W-2:0], sda_s_i};
            bit_cnt <= bit_cnt + CNT_W'(1);
            if (bit_cnt == '0) ack_eff <= ack_level_i;
          end else begin
            load_o <= 1'b1;
            state  <= ST_DATA;
          end
        end else if (scl_fall_i) begin
          if (!in_ack && bit_cnt == LAST_BIT) begin
            if (state == ST_ADDR && !addr_hit) begin
              state <= ST_SKIP;
            end else begin
              in_ack     <= 1'b1;
              sda_pull_o <= ~ack_eff;
              hold_o     <= rx_full_i;
            end
          end else if (in_ack) begin
            in_ack     <= 1'b0;
            sda_pull_o <= 1'b0;
            bit_cnt    <= '0;
          end
        end
      end
    end
  end

  assign shift_o = shreg;

  assert_sda_chg_scl_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$stable(sda_pull_o)) |-> !scl_s_i);
  assert_sda_only_addressed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_o |-> active);
  assert_hold_in_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> in_ack);
endmodule

// File: rtl/i2c_rx_regs.sv
`timescale 1ns/1ps
module i2c_rx_regs
  import i2c_rx_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] OWN_RST = 7'h2A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              en_o,
  output logic              ack_level_o,
  output logic [ADDR_W-1:0] own_addr_o,
  output logic              rx_full_o
);
  logic [DATA_W-1:0] rx_buf;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:ADDR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o        <= 1'b0;
      ack_level_o <= 1'b0;
      own_addr_o  <= OWN_RST;
    end else if (wr_i) begin
      if (addr_i == REG_CTRL) {ack_level_o, en_o} <= wdata_i[1:0];
      if (addr_i == REG_OWN)  own_addr_o <= wdata_i[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_buf    <= '0;
      rx_full_o <= 1'b0;
    end else if (!en_o) begin
      rx_buf    <= '0;
      rx_full_o <= 1'b0;
    end else if (load_i) begin
      rx_buf    <= load_data_i;
      rx_full_o <= 1'b1;
    end else if (rd_i && addr_i == REG_DATA) begin
      rx_full_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: rdata_o[1:0] = {ack_level_o, en_o};
      REG_OWN:  rdata_o[ADDR_W-1:0] = own_addr_o;
      REG_STAT: rdata_o[0] = rx_full_o;
      REG_DATA: rdata_o = rx_buf;
      default:  rdata_o = '0;
    endcase
  end

  assert_rd_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && rd_i && addr_i == REG_DATA && !load_i) |=> !rx_full_o);
  assert_dis_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> (!rx_full_o && rx_buf == '0));
endmodule

// File: rtl/i2c_slave_rx.sv
`timescale 1ns/1ps
module i2c_slave_rx #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] OWN_RST = 7'h2A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, start_ev, stop_ev;
  logic              en, ack_level, rx_full, load, hold;
  logic [ADDR_W-1:0] own_addr;
  logic [DATA_W-1:0] shift;

  i2c_rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i2c_rx_cond i_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_ev),
    .stop_o    (stop_ev)
  );

  i2c_rx_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .own_addr_i (own_addr),
    .ack_level_i(ack_level),
    .rx_full_i  (rx_full),
    .load_o     (load),
    .shift_o    (shift),
    .sda_pull_o (sda_pull_o),
    .hold_o     (hold)
  );

  i2c_rx_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OWN_RST(OWN_RST)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .load_i     (load),
    .load_data_i(shift),
    .en_o       (en),
    .ack_level_o(ack_level),
    .own_addr_o (own_addr),
    .rx_full_o  (rx_full)
  );

  // read clears full in the same cycle, so the stretch ends without waiting on hold
  assign scl_pull_o = hold & rx_full;

  assert_scl_hold_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_pull_o |-> rx_full);
  assert_full_on_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full) |-> $past(scl_rise, 2));
  assert_idle_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && $past(!en)) |-> (!scl_pull_o && !sda_pull_o));
endmodule

// File: tb/test_i2c_slave_rx.sv
`timescale 1ns/1ps
module test_i2c_slave_rx;
  localparam int HALF = 20;
  localparam logic [6:0] OWN = 7'h2A;
  // {addr[6:0], rw, data[7:0], ack_level, addressed}
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {7'h2A, 1'b0, 8'h5C, 1'b0, 1'b1},
    {7'h2B, 1'b0, 8'h11, 1'b0, 1'b0},
    {7'h2A, 1'b1, 8'h22, 1'b0, 1'b0},
    {7'h2A, 1'b0, 8'hA3, 1'b1, 1'b1},
    {7'h2A, 1'b0, 8'h00, 1'b0, 1'b1},
    {7'h55, 1'b0, 8'hFF, 1'b0, 1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_pull_o, sda_pull_o;
  logic reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'd0;
  logic [7:0] reg_rdata_o;
  logic scl_line, sda_line;
  int n_chk = 0, n_bad = 0;

  assign scl_line = m_scl & ~scl_pull_o;
  assign sda_line = m_sda & ~sda_pull_o;

  always #2.5 clk_i = ~clk_i;

  i2c_slave_rx i_i2c_slave_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_rd_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
  endtask

  task automatic scl_high();
    m_scl = 1'b1;
    while (!scl_line) @(posedge clk_i);
    wait_clk(HALF);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_clk(HALF);
    scl_high();
    m_sda = 1'b0; wait_clk(HALF);
    m_scl = 1'b0; wait_clk(HALF);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clk(HALF);
    scl_high();
    m_sda = 1'b1; wait_clk(HALF);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wait_clk(HALF);
    scl_high();
    m_scl = 1'b0;
  endtask

  task automatic send_bits8(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wait_clk(HALF);
  endtask

  task automatic ack_clock(output logic a);
    m_sda = 1'b1;
    m_scl = 1'b1;
    while (!scl_line) @(posedge clk_i);
    wait_clk(HALF);
    #1 a = sda_line;
    m_scl = 1'b0; wait_clk(HALF);
  endtask

  initial begin
    wait_clk(150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic a;
    wait_clk(5);
    #1 rst_ni = 1'b1;
    wait_clk(3);

    // R1 reset state
    check("R1 scl_pull", {7'd0, scl_pull_o}, 8'd0);
    check("R1 sda_pull", {7'd0, sda_pull_o}, 8'd0);
    host_rd(2'd2, d); check("R1 status", d, 8'd0);
    host_rd(2'd3, d); check("R1 data", d, 8'd0);
    host_rd(2'd1, d); check("R2 own addr reset", d, {1'b0, OWN});

    // table walk: R2 R3 R4 R5 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [6:0] va; logic vrw; logic [7:0] vd; logic vack; logic vhit; logic exp_a;
      {va, vrw, vd, vack, vhit} = VEC[v];
      exp_a = vhit ? vack : 1'b1;
      host_wr(2'd0, {6'd0, vack, 1'b1});
      bus_start();
      send_bits8({va, vrw});
      ack_clock(a);
      check(vhit ? "R3 addr ack level" : "R8 addr ignored", {7'd0, a}, {7'd0, exp_a});
      host_rd(2'd2, d);
      check(vhit ? "R4 flag on addr" : "R8 no load", d, {7'd0, vhit});
      if (vhit) begin
        host_rd(2'd3, d); check("R4 dummy addr byte", d, {va, vrw});
        host_rd(2'd2, d); check("R5 read clears flag", d, 8'd0);
      end
      send_bits8(vd);
      ack_clock(a);
      check(vhit ? "R3 data ack level" : "R8 data ignored", {7'd0, a}, {7'd0, exp_a});
      host_rd(2'd2, d);
      check(vhit ? "R5 flag on data" : "R8 no data load", d, {7'd0, vhit});
      if (vhit) begin
        host_rd(2'd3, d); check("R5 data byte", d, vd);
      end
      bus_stop();
      check("R9 lines free after stop", {6'd0, scl_pull_o, sda_pull_o}, 8'd0);
    end

    // R6 stretch, R7 late ack-level change
    host_wr(2'd0, 8'h01);
    bus_start();
    send_bits8({OWN, 1'b0});
    ack_clock(a); check("R3 ack stretch run", {7'd0, a}, 8'd0);
    send_bits8(8'hC3);
    m_sda = 1'b1; m_scl = 1'b1;
    wait_clk(60);
    check("R6 scl held", {7'd0, scl_line}, 8'd0);
    check("R3 ack during hold", {7'd0, sda_line}, 8'd0);
    host_wr(2'd0, 8'h03);
    check("R6 still held after write", {7'd0, scl_line}, 8'd0);
    host_rd(2'd3, d); check("R4 dummy under hold", d, {OWN, 1'b0});
    wait_clk(4);
    check("R6 released by read", {7'd0, scl_line}, 8'd1);
    wait_clk(HALF);
    #1 check("R7 old ack level kept", {7'd0, sda_line}, 8'd0);
    m_scl = 1'b0; wait_clk(HALF);
    host_rd(2'd3, d); check("R5 stretched byte", d, 8'hC3);
    send_bits8(8'h3C);
    ack_clock(a); check("R7 new level next byte", {7'd0, a}, 8'd1);
    host_rd(2'd3, d); check("R5 last byte", d, 8'h3C);
    host_rd(2'd2, d); check("R5 flag clear after last", d, 8'd0);
    bus_stop();

    // R9 repeated START mid-byte
    host_wr(2'd0, 8'h01);
    bus_start();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    wait_clk(HALF);
    bus_start();
    send_bits8({OWN, 1'b0});
    ack_clock(a); check("R9 rematch after restart", {7'd0, a}, 8'd0);
    host_rd(2'd3, d); check("R9 addr after restart", d, {OWN, 1'b0});
    bus_stop();

    // R10 disable clears, R1 ignored while off
    bus_start();
    send_bits8({OWN, 1'b0});
    ack_clock(a);
    bus_stop();
    host_rd(2'd2, d); check("R4 flag before disable", d, 8'd1);
    host_wr(2'd0, 8'h00);
    host_rd(2'd2, d); check("R10 flag cleared", d, 8'd0);
    host_rd(2'd3, d); check("R10 buffer cleared", d, 8'd0);
    bus_start();
    send_bits8({OWN, 1'b0});
    ack_clock(a); check("R1 no ack when off", {7'd0, a}, 8'd1);
    bus_stop();
    host_rd(2'd2, d); check("R1 no load when off", d, 8'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule